// File: doc/BRIEF.md
# Configuration Access Error Capture

This block sits next to a configuration-space decoder. Each cycle the decoder presents one access: its direction, the 32-bit configuration address, the byte offset inside the dword, the size, and three qualifiers (the IDSEL decoded to a real slot, a device answers at that slot, the addressed register is implemented). When any qualifier is false, the access is faulting. The block then supplies the value a read must return and records the access so that software can inspect it later.

The block keeps only the first faulting access. A fault that arrives while a record is held sets a sticky overflow flag and leaves the record as it was. Software writes the clear strobe to drop the record and the overflow flag. Unknown fields are flagged by their own valid bits. Write data is stored most-significant byte first.

Top module: `cfg_err_capture`

## Requirements
- R1: A faulting read whose IDSEL is invalid or whose device is absent returns `rd_data_o` = 32'hFFFF_FFFF in the same cycle. Writes and non-faulting accesses give `rd_data_o` = 0.
- R2: A faulting read of an unimplemented register in a present device returns zero. Register 1 is the exception (R3).
- R3: An unimplemented read of register 1 in a present device uses the dword {STATUS_DFLT, 16'h0}, with STATUS_DFLT = 16'h02B0 by default. The returned value is that dword rotated right by 8×offset (the offset wraps past byte 3), then masked to the size (code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R4: An access with `acc_valid_i` high and any of `idsel_ok_i`, `dev_present_i`, `reg_impl_i` low raises `acc_err_o` in that cycle. If no record is held, `cap_valid_o` is 1 from the next cycle on. Accesses that are not faulting are never recorded.
- R5: `cap_write_o` records the direction. A read record holds `cap_wdata_o` = 0.
- R6: Write data arrives with its bytes reversed in the low bytes of `wdata_i`, and the unused upper bytes are ignored. The stored value is as follows:
  - size 1: byte 0 unchanged;
  - size 2: {byte0, byte1} zero-extended;
  - size 4: all four bytes reversed.
- R7: When IDSEL is invalid, `cap_fld_vld_o` = 4'b0000, the device, function and register fields are 0, and `cap_raw_addr_o` holds the full address.
- R8: When IDSEL is valid, the record holds the following fields, with `cap_fld_vld_o` = {reg, fn, dev, bus} = 4'b1110 and `cap_raw_addr_o` = 0:
  - device: the index of the lowest set bit of address[31:11];
  - function: address[10:8];
  - register: address[7:2].
- R9: The record holds the byte offset and the size code of the access.
- R10: While a record is held, a further fault sets `cap_ovf_o` and leaves every record field unchanged.
- R11: `clear_i` drops `cap_valid_o` and `cap_ovf_o` on the next edge. A fault in the same cycle as the clear is recorded as a fresh record with overflow at 0.
- R12: After reset, `cap_valid_o` and `cap_ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | 32 | Configuration address |
| byte_off_i | input | 2 | Byte offset within the dword |
| size_i | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| idsel_ok_i | input | 1 | IDSEL decoded to a real slot |
| dev_present_i | input | 1 | A device answers at the slot |
| reg_impl_i | input | 1 | The addressed register is implemented |
| wdata_i | input | 32 | Write data, bytes reversed |
| clear_i | input | 1 | Software clear of the record |
| acc_err_o | output | 1 | The current access is faulting |
| rd_data_o | output | 32 | Read-return value for a faulting read |
| cap_valid_o | output | 1 | A record is held |
| cap_ovf_o | output | 1 | A fault was dropped while a record was held |
| cap_write_o | output | 1 | Direction of the recorded access |
| cap_fld_vld_o | output | 4 | Field known bits {reg, fn, dev, bus} |
| cap_dev_o | output | 5 | Recorded device number |
| cap_fn_o | output | 3 | Recorded function |
| cap_reg_o | output | 6 | Recorded dword register number |
| cap_off_o | output | 2 | Recorded byte offset |
| cap_size_o | output | 2 | Recorded size code |
| cap_wdata_o | output | 32 | Recorded write value, most significant byte first |
| cap_raw_addr_o | output | 32 | Raw address for an invalid-IDSEL access |

## Verification
The assertions assume three things about the inputs. A valid IDSEL comes with at least one set bit in address[31:11]. Size codes stay within 0 to 2. `clear_i` is a single-cycle strobe from software. The directed stimulus follows these rules: every valid-IDSEL address it sends has exactly one slot bit set, and it never drives size code 3. It pulses the clear on its own between scenarios, except in one case where the clear is placed on purpose in the same cycle as a fault.

// File: rtl/cfg_err_pkg.sv
package cfg_err_pkg;
  localparam int unsigned CFG_AW   = 32;
  localparam int unsigned CFG_DW   = 32;
  localparam int unsigned SLOT_LO  = 11;
  localparam int unsigned SLOT_W   = CFG_AW - SLOT_LO;
  localparam int unsigned DEV_W    = $clog2(SLOT_W);
  localparam int unsigned FN_W     = 3;
  localparam int unsigned REG_W    = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic              write;
    logic              reg_vld;
    logic              fn_vld;
    logic              dev_vld;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   fn;
    logic [REG_W-1:0]  regn;
    logic [1:0]        off;
    logic [1:0]        size;
    logic [CFG_DW-1:0] wdata;
    logic [CFG_AW-1:0] raw;
  } cap_rec_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_err_pkg::*;
(
  input  logic [CFG_AW-1:2] addr_i,
  output logic [DEV_W-1:0]  dev_o,
  output logic [FN_W-1:0]   fn_o,
  output logic [REG_W-1:0]  reg_o
);
  logic [SLOT_W-1:0] slot;
  assign slot  = addr_i[CFG_AW-1:SLOT_LO];
  assign fn_o  = addr_i[SLOT_LO-1:SLOT_LO-FN_W];
  assign reg_o = addr_i[REG_W+1:2];

  // lowest set slot bit wins
  always_comb begin
    dev_o = '0;
    for (int i = SLOT_W - 1; i >= 0; i--) begin
      if (slot[i]) dev_o = DEV_W'(i);
    end
  end
endmodule

// File: rtl/cfg_wdata_order.sv
module cfg_wdata_order
  import cfg_err_pkg::*;
(
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic [1:0]        size_i,
  output logic [CFG_DW-1:0] msb_first_o
);
  localparam int unsigned NB = CFG_DW / 8;

  logic [CFG_DW-1:0] full_rev;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign full_rev[8*b +: 8] = wdata_i[8*(NB-1-b) +: 8];
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: msb_first_o = {{(CFG_DW-8){1'b0}}, wdata_i[7:0]};
      SZ_HALF: msb_first_o = {{(CFG_DW-16){1'b0}}, wdata_i[7:0], wdata_i[15:8]};
      default: msb_first_o = full_rev;
    endcase
  end
endmodule

// File: rtl/cfg_rd_default.sv
module cfg_rd_default
  import cfg_err_pkg::*;
#(
  parameter logic [15:0]      STATUS_DFLT = 16'h02B0,
  parameter logic [REG_W-1:0] STATUS_REG  = REG_W'(1)
) (
  input  logic              absent_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        size_i,
  output logic [CFG_DW-1:0] rdata_o
);
  logic [CFG_DW-1:0]   dword;
  logic [2*CFG_DW-1:0] dbl;
  logic [CFG_DW-1:0]   rot;
  logic [CFG_DW-1:0]   mask;

  assign dword = (reg_i == STATUS_REG) ? {STATUS_DFLT, 16'h0000} : '0;
  assign dbl   = {dword, dword} >> {off_i, 3'b000};
  assign rot   = dbl[CFG_DW-1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = 32'h0000_00FF;
      SZ_HALF: mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  assign rdata_o = absent_i ? '1 : (rot & mask);
endmodule

// File: rtl/cfg_err_capture.sv
module cfg_err_capture
  import cfg_err_pkg::*;
#(
  parameter logic [15:0] STATUS_DFLT = 16'h02B0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [31:0]       cfg_addr_i,
  input  logic [1:0]        byte_off_i,
  input  logic [1:0]        size_i,
  input  logic              idsel_ok_i,
  input  logic              dev_present_i,
  input  logic              reg_impl_i,
  input  logic [31:0]       wdata_i,
  input  logic              clear_i,
  output logic              acc_err_o,
  output logic [31:0]       rd_data_o,
  output logic              cap_valid_o,
  output logic              cap_ovf_o,
  output logic              cap_write_o,
  output logic [3:0]        cap_fld_vld_o,
  output logic [4:0]        cap_dev_o,
  output logic [2:0]        cap_fn_o,
  output logic [5:0]        cap_reg_o,
  output logic [1:0]        cap_off_o,
  output logic [1:0]        cap_size_o,
  output logic [31:0]       cap_wdata_o,
  output logic [31:0]       cap_raw_addr_o
);
  logic             err_now, absent;
  logic [DEV_W-1:0] dec_dev;
  logic [FN_W-1:0]  dec_fn;
  logic [REG_W-1:0] dec_reg;
  logic [31:0]      wd_msb, rd_dflt;
  cap_rec_t         rec_new, rec_q;
  logic             vld_q, ovf_q;

  cfg_addr_decode u_dec (
    .addr_i (cfg_addr_i[31:2]),
    .dev_o  (dec_dev),
    .fn_o   (dec_fn),
    .reg_o  (dec_reg)
  );

  cfg_wdata_order u_ord (
    .wdata_i     (wdata_i),
    .size_i      (size_i),
    .msb_first_o (wd_msb)
  );

  cfg_rd_default #(.STATUS_DFLT(STATUS_DFLT)) u_rdd (
    .absent_i (absent),
    .reg_i    (dec_reg),
    .off_i    (byte_off_i),
    .size_i   (size_i),
    .rdata_o  (rd_dflt)
  );

  assign absent    = !idsel_ok_i || !dev_present_i;
  assign err_now   = acc_valid_i && (absent || !reg_impl_i);
  assign acc_err_o = err_now;
  assign rd_data_o = (err_now && !acc_write_i) ? rd_dflt : '0;

  always_comb begin
    rec_new         = '0;
    rec_new.write   = acc_write_i;
    rec_new.off     = byte_off_i;
    rec_new.size    = size_i;
    rec_new.wdata   = acc_write_i ? wd_msb : '0;
    if (idsel_ok_i) begin
      rec_new.dev_vld = 1'b1;
      rec_new.fn_vld  = 1'b1;
      rec_new.reg_vld = 1'b1;
      rec_new.dev     = dec_dev;
      rec_new.fn      = dec_fn;
      rec_new.regn    = dec_reg;
    end else begin
      rec_new.raw     = cfg_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
      rec_q <= '0;
    end else if (clear_i) begin
      vld_q <= err_now;
      ovf_q <= 1'b0;
      if (err_now) rec_q <= rec_new;
    end else if (err_now) begin
      if (!vld_q) begin
        vld_q <= 1'b1;
        rec_q <= rec_new;
      end else begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign cap_valid_o    = vld_q;
  assign cap_ovf_o      = ovf_q;
  assign cap_write_o    = rec_q.write;
  assign cap_fld_vld_o  = {rec_q.reg_vld, rec_q.fn_vld, rec_q.dev_vld, 1'b0};
  assign cap_dev_o      = rec_q.dev;
  assign cap_fn_o       = rec_q.fn;
  assign cap_reg_o      = rec_q.regn;
  assign cap_off_o      = rec_q.off;
  assign cap_size_o     = rec_q.size;
  assign cap_wdata_o    = rec_q.wdata;
  assign cap_raw_addr_o = rec_q.raw;

  // R10
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o && !clear_i |=> cap_valid_o);
  // R10
  rec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o && !clear_i |=> $stable(cap_wdata_o) && $stable(cap_raw_addr_o)
                               && $stable(cap_dev_o) && $stable(cap_write_o));
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ovf_o |-> cap_valid_o);
  // R11
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !acc_err_o |=> !cap_valid_o && !cap_ovf_o);
  // R5
  rd_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o && !cap_write_o |-> cap_wdata_o == '0);
  // R7
  raw_only_unknown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_o && cap_fld_vld_o[1] |-> cap_raw_addr_o == '0);
  // R4
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |=> cap_valid_o);
endmodule

// File: tb/cfg_err_capture_test.sv
module cfg_err_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0, idsel_ok = 0, dev_present = 0, reg_impl = 0, clear = 0;
  logic [31:0] cfg_addr = 0, wdata = 0;
  logic [1:0]  byte_off = 0, size = 0;
  logic        acc_err, cap_valid, cap_ovf, cap_write;
  logic [31:0] rd_data, cap_wdata, cap_raw;
  logic [3:0]  cap_fld_vld;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [5:0]  cap_reg;
  logic [1:0]  cap_off, cap_size;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_err_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .cfg_addr_i(cfg_addr), .byte_off_i(byte_off), .size_i(size), .idsel_ok_i(idsel_ok),
    .dev_present_i(dev_present), .reg_impl_i(reg_impl), .wdata_i(wdata), .clear_i(clear),
    .acc_err_o(acc_err), .rd_data_o(rd_data), .cap_valid_o(cap_valid), .cap_ovf_o(cap_ovf),
    .cap_write_o(cap_write), .cap_fld_vld_o(cap_fld_vld), .cap_dev_o(cap_dev), .cap_fn_o(cap_fn),
    .cap_reg_o(cap_reg), .cap_off_o(cap_off), .cap_size_o(cap_size), .cap_wdata_o(cap_wdata),
    .cap_raw_addr_o(cap_raw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, rd_data checked combinationally, capture visible next negedge
  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] off,
                        input logic [1:0] sz, input bit ids, input bit pres, input bit impl,
                        input logic [31:0] wd, input bit clr, input string req,
                        input logic [31:0] exp_rd);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; cfg_addr = a; byte_off = off; size = sz;
    idsel_ok = ids; dev_present = pres; reg_impl = impl; wdata = wd; clear = clr;
    #1 chk(req, rd_data, exp_rd);
    @(negedge clk);
    acc_valid = 0; clear = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    chk("R11 valid cleared", {31'b0, cap_valid}, 0);
    chk("R11 ovf cleared", {31'b0, cap_ovf}, 0);
  endtask

  task automatic t_reset();
    chk("R12 valid after reset", {31'b0, cap_valid}, 0);
    chk("R12 ovf after reset", {31'b0, cap_ovf}, 0);
  endtask

  task automatic t_absent_read();
    // slot bit 13 -> dev 2, fn 3, reg 5
    access(0, 32'h0000_2314, 2'd1, 2'd0, 1, 0, 1, 32'hDEAD_BEEF, 0, "R1 absent read ones", 32'hFFFF_FFFF);
    chk("R4 captured", {31'b0, cap_valid}, 1);
    chk("R5 read dir", {31'b0, cap_write}, 0);
    chk("R5 read wdata zero", cap_wdata, 0);
    chk("R8 dev", {27'b0, cap_dev}, 2);
    chk("R8 fn", {29'b0, cap_fn}, 3);
    chk("R8 reg", {26'b0, cap_reg}, 5);
    chk("R8 fld_vld", {28'b0, cap_fld_vld}, 4'b1110);
    chk("R8 raw zero", cap_raw, 0);
    chk("R9 off", {30'b0, cap_off}, 1);
    chk("R9 size", {30'b0, cap_size}, 0);
  endtask

  task automatic t_overflow();
    access(1, 32'h0010_0000, 2'd0, 2'd2, 1, 1, 0, 32'h1111_1111, 0, "R1 write rd zero", 0);
    chk("R10 ovf set", {31'b0, cap_ovf}, 1);
    chk("R10 record kept dev", {27'b0, cap_dev}, 2);
    chk("R10 record kept dir", {31'b0, cap_write}, 0);
    do_clear();
  endtask

  task automatic t_unused_reads();
    // slot bit 11 -> dev 0; reg 7
    access(0, 32'h0000_081C, 2'd0, 2'd2, 1, 1, 0, 0, 0, "R2 unused reg zero", 0);
    chk("R8 dev lowest slot", {27'b0, cap_dev}, 0);
    do_clear();
    access(0, 32'h0000_0804, 2'd2, 2'd1, 1, 1, 0, 0, 0, "R3 status half", 32'h0000_02B0);
    access(0, 32'h0000_0804, 2'd0, 2'd2, 1, 1, 0, 0, 0, "R3 status dword", 32'h02B0_0000);
    access(0, 32'h0000_0804, 2'd3, 2'd0, 1, 1, 0, 0, 0, "R3 status byte3", 32'h0000_0002);
    access(0, 32'h0000_0804, 2'd3, 2'd1, 1, 1, 0, 0, 0, "R3 status wrap", 32'h0000_0002);
    do_clear();
  endtask

  task automatic t_writes();
    access(1, 32'h0001_6800, 2'd0, 2'd2, 0, 0, 0, 32'h7856_3412, 0, "R1 write rd zero", 0);
    chk("R6 word swap", cap_wdata, 32'h1234_5678);
    chk("R5 write dir", {31'b0, cap_write}, 1);
    chk("R7 raw addr", cap_raw, 32'h0001_6800);
    chk("R7 fld_vld", {28'b0, cap_fld_vld}, 0);
    chk("R7 dev zero", {27'b0, cap_dev}, 0);
    do_clear();
    access(1, 32'h0000_4008, 2'd2, 2'd1, 1, 0, 1, 32'hFFFF_3412, 0, "R1 write rd zero", 0);
    chk("R6 half swap upper ignored", cap_wdata, 32'h0000_1234);
    chk("R9 off half", {30'b0, cap_off}, 2);
    chk("R9 size half", {30'b0, cap_size}, 1);
    do_clear();
    access(1, 32'h0000_4008, 2'd3, 2'd0, 1, 0, 1, 32'hCDCD_CDAB, 0, "R1 write rd zero", 0);
    chk("R6 byte unchanged", cap_wdata, 32'h0000_00AB);
  endtask

  task automatic t_clear_with_err();
    chk("R11 pre valid", {31'b0, cap_valid}, 1);
    access(0, 32'h0000_8000, 2'd0, 2'd2, 1, 0, 1, 0, 1, "R1 absent read ones", 32'hFFFF_FFFF);
    chk("R11 fresh valid", {31'b0, cap_valid}, 1);
    chk("R11 fresh ovf zero", {31'b0, cap_ovf}, 0);
    chk("R11 fresh dev", {27'b0, cap_dev}, 4);
    do_clear();
  endtask

  task automatic t_no_error();
    access(0, 32'h0000_0800, 2'd0, 2'd2, 1, 1, 1, 0, 0, "R1 ok access rd zero", 0);
    chk("R4 no capture", {31'b0, cap_valid}, 0);
    @(negedge clk);
    acc_valid = 1; idsel_ok = 1; dev_present = 1; reg_impl = 1;
    #1 chk("R4 no err flag", {31'b0, acc_err}, 0);
    idsel_ok = 0;
    #1 chk("R4 err flag", {31'b0, acc_err}, 1);
    @(negedge clk); acc_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_absent_read();
    t_overflow();
    t_unused_reads();
    t_writes();
    t_clear_with_err();
    t_no_error();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule